// File: doc/BRIEF.md
# Byte Parity Checker and Generator

This block guards a byte-organized data bus in which every byte carries eight data bits and one parity bit in its top position. On the inbound path it tests each byte of the incoming bus against the selected parity sense. It then drives an active-low error flag, registered on the port clock, that goes low when any byte enabled by the width mask is wrong. On the outbound path, during a read with generation enabled, it rebuilds the parity bit of every byte of the word being read and delivers the corrected word one cycle later.

A single parity tree per byte lane serves both directions. While a read with generation is active, each tree is steered to the outgoing word instead of the incoming bus. For that cycle the error flag is held inactive, whatever the bus carries. A per-byte mask lets a narrower port mode exclude byte lanes it does not use. A single select line chooses odd or even parity for both checking and generation.

Top module: `byte_parity_unit`

## Requirements
- R1: A synchronous active-high reset sets `perr_n` high and `rd_out` to all zeros at the next rising edge.
- R2: Byte lane i occupies bits [9i+8 : 9i] of `bus_in`, `rd_word` and `rd_out`. Bit 9i+8 is the lane's parity bit and bits [9i+7 : 9i] are its data bits.
- R3: With `odd_sel`=1, a byte passes only when its nine bits hold an odd number of ones. With `odd_sel`=0, it passes only when they hold an even number. `perr_n` goes low when a checked byte fails and stays high when all checked bytes pass.
- R4: `perr_n` is registered. It reflects the inputs sampled at the previous rising edge and does not change between edges.
- R5: A byte lane is checked only when its `size_mask` bit is 1 (bit i enables lane i). A lane whose mask bit is 0 never pulls `perr_n` low.
- R6: When `gen_en` and `rd_active` are both 1, each lane of `rd_out` at the next edge carries the data bits of `rd_word`. Its parity bit is recomputed from those eight data bits so that the nine bits satisfy the parity chosen by `odd_sel`. The parity bit in `rd_word` is ignored.
- R7: When `gen_en` and `rd_active` are both 1, `perr_n` is high at the next edge regardless of `bus_in` and `size_mask`.
- R8: When `gen_en` and `rd_active` are not both 1, `rd_out` at the next edge equals `rd_word` unchanged, and checking of `bus_in` proceeds as in R3 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| gen_en | input | 1 | Enables parity generation on reads |
| rd_active | input | 1 | A read is in progress this cycle |
| size_mask | input | NUM_BYTES | Per-lane check enable for narrow bus modes |
| bus_in | input | NUM_BYTES*(DATA_BITS+1) | Incoming bus to be checked |
| rd_word | input | NUM_BYTES*(DATA_BITS+1) | Outgoing word being read |
| perr_n | output | 1 | Registered parity error flag, active low |
| rd_out | output | NUM_BYTES*(DATA_BITS+1) | Registered outgoing word, parity regenerated when enabled |

## Verification
The bench builds the block with NUM_BYTES=2 and DATA_BITS=8, an 18-bit bus of two lanes. With this size it can sweep every 9-bit value of each lane under both parity senses. It also covers all sixteen pairings of bad-lane pattern and size mask. Generation is swept over all 256 data values, with both states of the stale parity bit and both parity senses, while the inbound bus is held corrupt to exercise the forced-inactive flag.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int unsigned BPU_DATA_BITS = 8;
  localparam int unsigned BPU_BYTES     = 4;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_kind_e;
endpackage

// File: rtl/bpu_lane.sv
module bpu_lane
  import bpu_pkg::*;
#(
  parameter int unsigned DATA_BITS = BPU_DATA_BITS
) (
  input  logic [DATA_BITS:0] src_byte,
  input  logic               odd_sel,
  output logic               fail,
  output logic [DATA_BITS:0] gen_byte
);
  par_kind_e kind;
  logic      tree;
  logic      want_one;

  assign kind     = par_kind_e'(odd_sel);
  assign want_one = (kind == PAR_ODD);

  // shared tree over the data bits only
  assign tree = ^src_byte[DATA_BITS-1:0];

  // checking: data tree plus stored bit must match the wanted sense
  assign fail = (tree ^ src_byte[DATA_BITS]) != want_one;

  // generation: computed bit placed in the top position
  assign gen_byte = {tree ^ want_one, src_byte[DATA_BITS-1:0]};
endmodule

// File: rtl/bpu_err_flag.sv
module bpu_err_flag #(
  parameter int unsigned NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BYTES-1:0] fail_vec,
  input  logic [NUM_BYTES-1:0] mask_vec,
  input  logic                 force_ok,
  output logic                 perr_n
);
  logic any_bad;

  assign any_bad = |(fail_vec & mask_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n <= 1'b1;
    end else begin
      perr_n <= force_ok ? 1'b1 : ~any_bad;
    end
  end

  // R5
  mask_off_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_vec == '0) |=> perr_n);

  // R7
  gen_forces_ok_chk: assert property (@(posedge clk) disable iff (rst)
    force_ok |=> perr_n);
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
  import bpu_pkg::*;
#(
  parameter int unsigned NUM_BYTES = BPU_BYTES,
  parameter int unsigned DATA_BITS = BPU_DATA_BITS
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               odd_sel,
  input  logic                               gen_en,
  input  logic                               rd_active,
  input  logic [NUM_BYTES-1:0]               size_mask,
  input  logic [NUM_BYTES*(DATA_BITS+1)-1:0] bus_in,
  input  logic [NUM_BYTES*(DATA_BITS+1)-1:0] rd_word,
  output logic                               perr_n,
  output logic [NUM_BYTES*(DATA_BITS+1)-1:0] rd_out
);
  localparam int unsigned LANE_W = DATA_BITS + 1;
  localparam int unsigned BUS_W  = NUM_BYTES * LANE_W;

  logic                 gen_act;
  logic [NUM_BYTES-1:0] fail_vec;
  logic [BUS_W-1:0]     gen_word;

  assign gen_act = gen_en & rd_active;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    logic [LANE_W-1:0] src;

    // one tree per lane: steered to the outgoing word while generating
    assign src = gen_act ? rd_word[i*LANE_W +: LANE_W]
                         : bus_in[i*LANE_W +: LANE_W];

    bpu_lane #(.DATA_BITS(DATA_BITS)) lane_i (
      .src_byte (src),
      .odd_sel  (odd_sel),
      .fail     (fail_vec[i]),
      .gen_byte (gen_word[i*LANE_W +: LANE_W])
    );

    // R6
    gen_lane_parity_chk: assert property (@(posedge clk) disable iff (rst)
      gen_act |=> ((^rd_out[i*LANE_W +: LANE_W]) == $past(odd_sel)));

    // R6
    gen_lane_data_chk: assert property (@(posedge clk) disable iff (rst)
      gen_act |=> (rd_out[i*LANE_W +: DATA_BITS] ==
                   $past(rd_word[i*LANE_W +: DATA_BITS])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_out <= '0;
    end else begin
      rd_out <= gen_act ? gen_word : rd_word;
    end
  end

  bpu_err_flag #(.NUM_BYTES(NUM_BYTES)) flag_i (
    .clk      (clk),
    .rst      (rst),
    .fail_vec (fail_vec),
    .mask_vec (size_mask),
    .force_ok (gen_act),
    .perr_n   (perr_n)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (perr_n && (rd_out == '0)));

  // R8
  passthrough_chk: assert property (@(posedge clk) disable iff (rst)
    !gen_act |=> (rd_out == $past(rd_word)));
endmodule

// File: tb/byte_parity_unit_tb_top.sv
`timescale 1ns/1ps
module byte_parity_unit_tb_top;
  localparam int NB = 2;
  localparam int DB = 8;
  localparam int LW = DB + 1;
  localparam int W  = NB * LW;

  logic          clk = 1'b0;
  logic          rst;
  logic          odd_sel;
  logic          gen_en;
  logic          rd_active;
  logic [NB-1:0] size_mask;
  logic [W-1:0]  bus_in;
  logic [W-1:0]  rd_word;
  logic          perr_n;
  logic [W-1:0]  rd_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  byte_parity_unit #(.NUM_BYTES(NB), .DATA_BITS(DB)) dut_i (
    .clk(clk), .rst(rst), .odd_sel(odd_sel), .gen_en(gen_en),
    .rd_active(rd_active), .size_mask(size_mask), .bus_in(bus_in),
    .rd_word(rd_word), .perr_n(perr_n), .rd_out(rd_out)
  );

  function automatic logic par_of(logic [7:0] d, logic odd);
    int c = 0;
    for (int k = 0; k < 8; k++) c += int'(d[k]);
    return ((c % 2) == 1) ? ~odd : odd;
  endfunction

  function automatic bit byte_ok(logic [8:0] b, logic odd);
    int c = 0;
    for (int k = 0; k < 9; k++) c += int'(b[k]);
    return (c % 2) == int'(odd);
  endfunction

  function automatic logic [8:0] good_byte(logic [7:0] d, logic odd);
    return {par_of(d, odd), d};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp_w;
    rst = 1'b1; odd_sel = 1'b0; gen_en = 1'b0; rd_active = 1'b0;
    size_mask = '1; bus_in = '1; rd_word = '1;
    repeat (3) tick();
    // R1 reset state
    check(perr_n == 1'b1, "R1", "perr_n after reset", perr_n, 1);
    check(rd_out == '0, "R1", "rd_out after reset", rd_out, 0);

    // R2/R3/R8 sweep every 9-bit value on each lane, both senses
    for (int b = 0; b < NB; b++) begin
      for (int o = 0; o < 2; o++) begin
        for (int v = 0; v < 512; v++) begin
          @(negedge clk);
          rst = 1'b0; odd_sel = o[0]; gen_en = 1'b0; rd_active = 1'b0;
          size_mask = '1;
          for (int l = 0; l < NB; l++) bus_in[l*LW +: LW] = good_byte(8'h5A, o[0]);
          bus_in[b*LW +: LW] = 9'(v);
          rd_word = ~bus_in;
          exp_w = ~bus_in;
          tick();
          check(perr_n == byte_ok(9'(v), o[0]), "R3", "perr_n lane sweep",
                perr_n, byte_ok(9'(v), o[0]));
          check(rd_out == exp_w, "R8", "passthrough in sweep", rd_out, exp_w);
        end
      end
    end

    // R4 registered flag
    @(negedge clk);
    odd_sel = 1'b1; size_mask = '1;
    for (int l = 0; l < NB; l++) bus_in[l*LW +: LW] = good_byte(8'h33, 1'b1);
    tick();
    @(negedge clk);
    bus_in[0 +: LW] = {~par_of(8'h33, 1'b1), 8'h33};
    #1;
    check(perr_n == 1'b1, "R4", "flag before edge", perr_n, 1);
    tick();
    check(perr_n == 1'b0, "R4", "flag after edge", perr_n, 0);
    @(negedge clk);
    bus_in[0 +: LW] = good_byte(8'h33, 1'b1);
    #1;
    check(perr_n == 1'b0, "R4", "flag holds until edge", perr_n, 0);
    tick();
    check(perr_n == 1'b1, "R4", "flag clears at edge", perr_n, 1);

    // R5 every bad-lane pattern against every mask
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        @(negedge clk);
        odd_sel = 1'b0; size_mask = 2'(m);
        for (int l = 0; l < NB; l++)
          bus_in[l*LW +: LW] = p[l] ? {~par_of(8'hC1, 1'b0), 8'hC1}
                                    : good_byte(8'hC1, 1'b0);
        tick();
        check(perr_n == !(|(2'(p) & 2'(m))), "R5", "mask vs bad lanes",
              perr_n, !(|(2'(p) & 2'(m))));
      end
    end

    // R6/R7 generation sweep with a corrupt inbound bus
    for (int o = 0; o < 2; o++) begin
      for (int d = 0; d < 256; d++) begin
        for (int pb = 0; pb < 2; pb++) begin
          @(negedge clk);
          odd_sel = o[0]; gen_en = 1'b1; rd_active = 1'b1; size_mask = '1;
          for (int l = 0; l < NB; l++) bus_in[l*LW +: LW] = {~par_of(8'hE7, o[0]), 8'hE7};
          rd_word[0 +: LW]  = {pb[0], 8'(d)};
          rd_word[LW +: LW] = {~pb[0], ~8'(d)};
          exp_w[0 +: LW]  = good_byte(8'(d), o[0]);
          exp_w[LW +: LW] = good_byte(~8'(d), o[0]);
          tick();
          check(rd_out == exp_w, "R6", "generated word", rd_out, exp_w);
          check(perr_n == 1'b1, "R7", "flag forced during generation", perr_n, 1);
        end
      end
    end

    // R8 generation enabled without read, and read without generation
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      odd_sel = 1'b1; gen_en = (c == 0); rd_active = (c == 1); size_mask = '1;
      for (int l = 0; l < NB; l++) bus_in[l*LW +: LW] = {~par_of(8'h0F, 1'b1), 8'h0F};
      rd_word = 18'h2A5C3;
      tick();
      check(rd_out == 18'h2A5C3, "R8", "no generation, passthrough", rd_out, 18'h2A5C3);
      check(perr_n == 1'b0, "R8", "checking still active", perr_n, 0);
    end

    // R1 reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    tick();
    check(perr_n == 1'b1 && rd_out == '0, "R1", "second reset", {perr_n, rd_out}, 19'h40000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule